// File: doc/BRIEF.md
# Pin Control Bank with Event Detection

This block holds the control state for a bank of general-purpose pins, with one 32-bit control word per pin. Each word sets the pin's multiplexer function, its direction, open-drain drive, pull resistor, power gating and output level, and one of six event-detect modes. From these words the block drives the pad-side select lines combinationally. It also samples every pad input through a two-flop synchronizer and raises one event bit per pin for a downstream interrupt aggregator.

Software writes a control word by addressing the pin by index on a single-cycle write strobe. Reads return the addressed word straight away, with the synchronized pad level merged into a read-only bit. Each pin has its own arming state machine with three states:

- **ARM_OFF**: detection is idle.
- **ARM_PRIME**: a one-cycle settling step.
- **ARM_WATCH**: full detection.

The transitions are:

- **go_prime**: ARM_OFF to ARM_PRIME, taken when the pin is powered and its mode is a valid detect code.
- **go_watch**: ARM_PRIME to ARM_WATCH, taken on the next cycle if the pin is still enabled.
- **go_off**: any state to ARM_OFF, taken as soon as the mode becomes disabled or invalid, or the pin is powered off.

Edges are only reported in ARM_WATCH, so a pin that has just been enabled or powered up never reports a stale transition.

Top module: `gpio_ctl_bank`

## Requirements
- R1: After reset every control word reads 0x0000_0040: power on, plain GPIO input, no pull, detect code 4 (disabled), output level 0. All pad-side outputs and all event bits are 0.
- R2: A write stores `wdata & 0x0001_37FF` into the addressed pin only. The writable fields are pull [1:0], power [3:2], detect [7:4], open-drain [8], direction [9], parallel-select [10], mux [13:12] and level [16]. All other bits read 0 except bit 24.
- R3: `alt_sel[2i+1:2i]` equals mux field [13:12] of pin i, where 0 is plain GPIO and 1 to 3 are alternate functions. `pad_oe[i]` is 1 only when direction bit [9] is 1, the mux field is 0 and the pin is powered.
- R4: `pad_out[i]` follows level bit [16]. `pad_od[i]` follows open-drain bit [8] while the pin is powered.
- R5: Pull field [1:0] set to 01 drives `pad_pu`, and set to 10 drives `pad_pd`. The codes 00 and 11 select no pull. Both pulls are never active together.
- R6: Power field [3:2] = 10 powers the pin off. In that state `pad_oe`, `pad_od`, `pad_pu`, `pad_pd` and `evt` stay 0 whatever the pad does. The other three power codes leave the pin powered.
- R7: Bit 24 of the read word is the pad level after a two-flop synchronizer. A pad change driven before clock edge k appears after edge k+1.
- R8: Detect field [7:4] uses these codes: 0x0 low level, 0x1 high level, 0x4 disabled, 0xD rising edge, 0xE falling edge, 0xF both edges. Every other code behaves as disabled and never raises `evt`.
- R9: In a level mode, `evt` is 1 on every cycle that the synchronized level matches. It holds from ARM_PRIME onward, which is one edge after the write that enables the mode.
- R10: In an edge mode, each qualifying change of the synchronized level raises `evt` for exactly one cycle. The pulse appears in the cycle where bit 24 changes.
- R11: Edge detection is masked in ARM_OFF and ARM_PRIME. A synchronized change that lands in the first cycle after enabling produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | Write when set together with bus_sel |
| bus_addr | input | AW | Pin index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Control word of addressed pin, with synchronized level in bit 24 |
| pad_in | input | NPINS | Raw pad inputs |
| pad_oe | output | NPINS | Output enable per pin |
| pad_out | output | NPINS | Output value per pin |
| pad_od | output | NPINS | Open-drain enable per pin |
| pad_pu | output | NPINS | Pull-up enable per pin |
| pad_pd | output | NPINS | Pull-down enable per pin |
| alt_sel | output | 2*NPINS | Mux function select, two bits per pin |
| evt | output | NPINS | Detected-event bit per pin |

## Verification
The hardest case to reach from the ports is a synchronized edge that lands in exactly the ARM_PRIME cycle. To get there, the bench changes the pad in the same cycle in which it writes a rising-edge mode. Two flops later the new level meets the one-cycle settling state, and the bench then re-arms the pin and toggles it to show that detection is live. The bench also sweeps all sixteen detect codes against one fixed pad waveform, and every power, pull, mux, direction, drive and level combination, predicting each output arithmetically.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;

    localparam int CTL_W = 32;

    localparam int PULL_LSB = 0;
    localparam int PWR_LSB  = 2;
    localparam int DET_LSB  = 4;
    localparam int OD_BIT   = 8;
    localparam int DIR_BIT  = 9;
    localparam int MUX_LSB  = 12;
    localparam int LVL_BIT  = 16;
    localparam int SYNC_BIT = 24;

    localparam logic [CTL_W-1:0] WR_MASK   = 32'h0001_37FF;
    localparam logic [CTL_W-1:0] CTL_RESET = 32'h0000_0040;

    localparam logic [1:0] PWR_OFF  = 2'b10;
    localparam logic [1:0] PULL_UP  = 2'b01;
    localparam logic [1:0] PULL_DN  = 2'b10;

    typedef enum logic [3:0] {
        DET_LOW  = 4'h0,
        DET_HIGH = 4'h1,
        DET_NONE = 4'h4,
        DET_RISE = 4'hD,
        DET_FALL = 4'hE,
        DET_BOTH = 4'hF
    } det_mode_e;

    typedef enum logic [1:0] {
        ARM_OFF,
        ARM_PRIME,
        ARM_WATCH
    } arm_state_e;

    function automatic logic det_enabled(input logic [3:0] m);
        return (m == DET_LOW) || (m == DET_HIGH) || (m == DET_RISE) ||
               (m == DET_FALL) || (m == DET_BOTH);
    endfunction

endpackage

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
    import gpio_ctl_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [CTL_W-1:0]       wr_data,
    output logic [NPINS*CTL_W-1:0] ctl_flat
);

    for (genvar i = 0; i < NPINS; i++) begin : g_word
        logic hit;
        assign hit = wr_en && (wr_addr == AW'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_flat[i*CTL_W +: CTL_W] <= CTL_RESET;
            end else if (hit) begin
                ctl_flat[i*CTL_W +: CTL_W] <= wr_data & WR_MASK;
            end
        end
    end

endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
    import gpio_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pad_raw,
    input  logic       pwr_off,
    input  logic [3:0] det_mode,
    output logic       pad_sync,
    output logic       evt
);

    logic       meta_q;
    logic       sync_q;
    logic       prev_q;
    arm_state_e st_q;
    arm_state_e st_d;
    logic       active;
    logic       level_hit;
    logic       edge_hit;
    logic       rise;
    logic       fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pad_raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign pad_sync = sync_q;
    assign active   = !pwr_off && det_enabled(det_mode);
    assign rise     = sync_q && !prev_q;
    assign fall     = !sync_q && prev_q;

    assign level_hit = ((det_mode == DET_LOW)  && !sync_q) ||
                       ((det_mode == DET_HIGH) &&  sync_q);
    assign edge_hit  = ((det_mode == DET_RISE) && rise) ||
                       ((det_mode == DET_FALL) && fall) ||
                       ((det_mode == DET_BOTH) && (rise || fall));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ARM_OFF;
        else        st_q <= st_d;
    end

    // transitions: go_prime, go_watch, go_off
    always_comb begin
        st_d = ARM_OFF;
        unique case (st_q)
            ARM_OFF:   st_d = active ? ARM_PRIME : ARM_OFF;
            ARM_PRIME: st_d = active ? ARM_WATCH : ARM_OFF;
            ARM_WATCH: st_d = active ? ARM_WATCH : ARM_OFF;
            default:   st_d = ARM_OFF;
        endcase
    end

    // outputs
    always_comb begin
        evt = 1'b0;
        unique case (st_q)
            ARM_OFF:   evt = 1'b0;
            ARM_PRIME: evt = active && level_hit;
            ARM_WATCH: evt = active && (level_hit || edge_hit);
            default:   evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_ctl_bank.sv
module gpio_ctl_bank
    import gpio_ctl_pkg::*;
#(
    parameter int NPINS = 32,
    localparam int AW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [AW-1:0]      bus_addr,
    input  logic [CTL_W-1:0]   bus_wdata,
    output logic [CTL_W-1:0]   bus_rdata,
    input  logic [NPINS-1:0]   pad_in,
    output logic [NPINS-1:0]   pad_oe,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pad_od,
    output logic [NPINS-1:0]   pad_pu,
    output logic [NPINS-1:0]   pad_pd,
    output logic [2*NPINS-1:0] alt_sel,
    output logic [NPINS-1:0]   evt
);

    logic [NPINS*CTL_W-1:0] ctl_flat;
    logic [NPINS-1:0]       sync_vec;

    gpio_ctl_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_sel && bus_we),
        .wr_addr  (bus_addr),
        .wr_data  (bus_wdata),
        .ctl_flat (ctl_flat)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [CTL_W-1:0] c;
        logic             off;
        logic [1:0]       mux;
        logic [1:0]       pull;

        assign c    = ctl_flat[i*CTL_W +: CTL_W];
        assign off  = (c[PWR_LSB +: 2] == PWR_OFF);
        assign mux  = c[MUX_LSB +: 2];
        assign pull = c[PULL_LSB +: 2];

        assign pad_oe[i]        = c[DIR_BIT] && (mux == 2'd0) && !off;
        assign pad_out[i]       = c[LVL_BIT];
        assign pad_od[i]        = c[OD_BIT] && !off;
        assign pad_pu[i]        = (pull == PULL_UP) && !off;
        assign pad_pd[i]        = (pull == PULL_DN) && !off;
        assign alt_sel[2*i +: 2] = mux;

        gpio_pin_detect u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .pad_raw  (pad_in[i]),
            .pwr_off  (off),
            .det_mode (c[DET_LSB +: 4]),
            .pad_sync (sync_vec[i]),
            .evt      (evt[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (bus_addr == AW'(i)) begin
                bus_rdata = ctl_flat[i*CTL_W +: CTL_W] |
                            (CTL_W'(sync_vec[i]) << SYNC_BIT);
            end
        end
    end

endmodule

// File: rtl/gpio_ctl_bank_chk.sv
module gpio_ctl_bank_chk #(
    parameter int NPINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NPINS*32-1:0] ctl_flat,
    input logic [NPINS-1:0]    pad_oe,
    input logic [NPINS-1:0]    pad_od,
    input logic [NPINS-1:0]    pad_pu,
    input logic [NPINS-1:0]    pad_pd,
    input logic [NPINS-1:0]    evt
);

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        logic [1:0] pwr;
        logic [1:0] mux;
        logic [3:0] det;
        logic       dir;

        assign pwr = ctl_flat[i*32 + 2 +: 2];
        assign det = ctl_flat[i*32 + 4 +: 4];
        assign dir = ctl_flat[i*32 + 9];
        assign mux = ctl_flat[i*32 + 12 +: 2];

        AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr == 2'b10) |-> !(pad_oe[i] || pad_od[i] || pad_pu[i] || pad_pd[i] || evt[i])); // R6

        AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
            !(pad_pu[i] && pad_pd[i])); // R5

        AST_OE_GPIO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            pad_oe[i] |-> (dir && mux == 2'd0)); // R3

        AST_INVALID_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            !(det == 4'h0 || det == 4'h1 || det == 4'hD || det == 4'hE || det == 4'hF)
            |-> !evt[i]); // R8

        AST_EDGE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            ((det == 4'hD || det == 4'hE) && evt[i])
            |=> (!evt[i] || det != $past(det))); // R10
    end

endmodule

bind gpio_ctl_bank gpio_ctl_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_flat (ctl_flat),
    .pad_oe   (pad_oe),
    .pad_od   (pad_od),
    .pad_pu   (pad_pu),
    .pad_pd   (pad_pd),
    .evt      (evt)
);

// File: tb/gpio_ctl_bank_test.sv
module gpio_ctl_bank_test;

    localparam int N  = 32;
    localparam int AW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [N-1:0]    pad_in = '0;
    logic [N-1:0]    pad_oe, pad_out, pad_od, pad_pu, pad_pd, evt;
    logic [2*N-1:0]  alt_sel;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    gpio_ctl_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .alt_sel(alt_sel), .evt(evt)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic wr(input int a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = AW'(a);
        #1;
        d = bus_rdata;
    endtask

    function automatic logic exp_evt(input int m, input logic sv, input logic pv);
        case (m)
            0:  return !sv;
            1:  return sv;
            13: return sv && !pv;
            14: return !sv && pv;
            15: return sv != pv;
            default: return 1'b0;
        endcase
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        logic [31:0] d;
        logic [14:0] seq;
        seq = 15'b010_0111_0001_0110;

        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        for (int p = 0; p < N; p++) begin
            rd(p, r);
            chk("R1 reset word", 64'(r), 64'h40);
        end
        chk("R1 reset outputs", {pad_oe, pad_out, pad_od, pad_pu, pad_pd, evt}, 64'h0);
        chk("R1 reset alt_sel", alt_sel, 64'h0);

        // R2 per-pin write/readback, no aliasing
        for (int p = 0; p < N; p++) begin
            d = (32'h9E37_79B9 * 32'(p + 1)) ^ (32'(p) << 12);
            wr(p, d);
        end
        for (int p = 0; p < N; p++) begin
            d = (32'h9E37_79B9 * 32'(p + 1)) ^ (32'(p) << 12);
            rd(p, r);
            chk("R2 readback", 64'(r), 64'(d & 32'h0001_37FF));
        end
        wr(7, 32'hFFFF_FFFF);
        rd(7, r);
        chk("R2 mask all-ones", 64'(r), 64'h0001_37FF);

        // R3 R4 R5 R6 exhaustive field sweep on pin 5
        for (int pull = 0; pull < 4; pull++)
        for (int pwr = 0; pwr < 4; pwr++)
        for (int od = 0; od < 2; od++)
        for (int dir = 0; dir < 2; dir++)
        for (int mux = 0; mux < 4; mux++)
        for (int lvl = 0; lvl < 2; lvl++) begin
            logic off;
            logic [6:0] e;
            d = 32'(pull) | (32'(pwr) << 2) | (32'h4 << 4) | (32'(od) << 8) |
                (32'(dir) << 9) | (32'(mux) << 12) | (32'(lvl) << 16);
            wr(5, d);
            off = (pwr == 2);
            e = {dir == 1 && mux == 0 && !off, lvl == 1, od == 1 && !off,
                 pull == 1 && !off, pull == 2 && !off, 2'(mux)};
            chk("R3/R4/R5/R6 pin outputs",
                64'({pad_oe[5], pad_out[5], pad_od[5], pad_pu[5], pad_pd[5], alt_sel[11:10]}),
                64'(e));
        end

        // R7 synchronizer latency on bit 24
        wr(9, 32'h40);
        wait_n(3);
        pad_in[9] = 1'b1;
        wait_n(1);
        rd(9, r);
        chk("R7 one edge later", 64'(r[24]), 64'h0);
        wait_n(1);
        rd(9, r);
        chk("R7 two edges later", 64'(r[24]), 64'h1);
        pad_in[9] = 1'b0;
        wait_n(2);
        rd(9, r);
        chk("R7 fall visible", 64'(r[24]), 64'h0);

        // R8 R9 R10 every detect code against one pad waveform on pin 3
        for (int m = 0; m < 16; m++) begin
            pad_in[3] = 1'b0;
            wr(3, 32'(m) << 4);
            wait_n(4);
            for (int j = 0; j < 18; j++) begin
                logic sv, pv;
                sv = (j >= 2 && j - 2 < 15) ? seq[j-2] : 1'b0;
                pv = (j >= 3 && j - 3 < 15) ? seq[j-3] : 1'b0;
                chk($sformatf("R8/R9/R10 mode %0d step %0d", m, j),
                    64'(evt[3]), 64'(exp_evt(m, sv, pv)));
                pad_in[3] = (j < 15) ? seq[j] : 1'b0;
                @(negedge clk);
            end
        end

        // R11 edge landing in the priming cycle is masked
        pad_in[3] = 1'b0;
        wr(3, 32'h40);
        wait_n(4);
        pad_in[3] = 1'b1;
        wr(3, 32'hD0);
        chk("R11 off after enable write", 64'(evt[3]), 64'h0);
        wait_n(1);
        chk("R11 edge during prime masked", 64'(evt[3]), 64'h0);
        wait_n(1);
        chk("R11 no late pulse in watch", 64'(evt[3]), 64'h0);
        pad_in[3] = 1'b0;
        wait_n(4);
        pad_in[3] = 1'b1;
        wait_n(2);
        chk("R11 armed edge fires", 64'(evt[3]), 64'h1);
        wait_n(1);
        chk("R10 pulse lasts one cycle", 64'(evt[3]), 64'h0);

        // R9 level event already asserted in the priming cycle
        wr(3, 32'h40);
        wait_n(4);
        wr(3, 32'h10);
        chk("R9 not yet in off state", 64'(evt[3]), 64'h0);
        wait_n(1);
        chk("R9 level during prime", 64'(evt[3]), 64'h1);

        // R6 powered-off pin stays quiet while pad toggles
        wr(3, 32'h0000_02F9);
        for (int k = 0; k < 8; k++) begin
            pad_in[3] = ~pad_in[3];
            @(negedge clk);
            chk("R6 powered off quiet",
                64'({evt[3], pad_oe[3], pad_pu[3], pad_od[3]}), 64'h0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule